// File: doc/BRIEF.md
# Video Line Capture Framebuffer Writer

This block sits between the video output of a retro computer and a simple SRAM framebuffer. It watches a one-bit-per-pixel stream that is qualified by a pixel-valid strobe and accompanied by horizontal and vertical sync. From the syncs it recovers where each line and each field begins. It skips a programmable back-porch interval at the start of every line. It then packs the next visible pixels into 16-bit words and issues one single-cycle SRAM write per completed word. Each line ends after a programmable number of words.

When successive fields place their vertical sync at different pixel positions within a line, the block treats the display as interlaced. It tags each field as odd or even and interleaves the two fields into alternating framebuffer rows. Otherwise it writes rows consecutively. Four run-time settings are held in a small register block that is reached over a request/response bus: a write enable, the back-porch length, the number of words per line and the framebuffer base address.

Top module: `vidcap_fb_writer`

## Requirements
- R1: After reset no SRAM write is issued, and reading any of the four setting registers returns 0.
- R2: A line begins on a pixel-valid cycle where hsync is 1 and was 0 on the previous pixel-valid cycle. That pixel has position 0, and each later pixel-valid cycle adds one. Cycles with pix_valid low change nothing, whatever the other inputs carry.
- R3: A pixel is captured only when its position within the line is greater than or equal to the back-porch setting.
- R4: Captured pixels are packed 16 to a word, with the first captured pixel in bit 15 and the last in bit 0. sram_we pulses for one cycle in the cycle after the 16th pixel is sampled. At most words-per-line words are written per line.
- R5: A partly filled word is dropped when the next line starts. A word that is completed by the last pixel before hsync is still written.
- R6: A field begins on a pixel-valid cycle where vsync rises. If hsync does not rise in that same cycle, nothing more is captured on that line and the next line is row 0. If both rise together, that line is row 0 and is captured.
- R7: At each field start, the vsync pixel position is compared with that of the previous field. If they differ, the display is interlaced and the field parity is 1 when the new position is the larger. If they are equal, or if this is the first field since reset, the display is progressive with parity 0.
- R8: Word k of a line goes to base + slot*words_per_line + k, modulo 2^16. The slot is the row when progressive, and 2*row + parity when interlaced.
- R9: When the enable bit is 0, no SRAM write is issued. Line, row and field tracking still advance, so writes resume at the correct row once the bit is set again.
- R10: Register map: 0 holds the enable in bit 0, 1 holds the back porch in bits 10:0, 2 holds words per line in bits 7:0, and 3 holds the base address in bits 15:0. Other addresses read 0. Each request gets csr_resp_valid one cycle later. A read returns the register's value masked to its field; a write returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Qualifies a pixel slot; all video inputs are sampled only when high |
| pix_data | input | 1 | Pixel value |
| hsync | input | 1 | Horizontal sync, rising edge starts a line |
| vsync | input | 1 | Vertical sync, rising edge starts a field |
| csr_req_valid | input | 1 | Register request strobe |
| csr_req_write | input | 1 | 1 for a write, 0 for a read |
| csr_req_addr | input | 4 | Register index |
| csr_req_wdata | input | 16 | Write data |
| csr_resp_valid | output | 1 | Response strobe, one cycle after the request |
| csr_resp_rdata | output | 16 | Read data |
| sram_we | output | 1 | Single-cycle SRAM write strobe |
| sram_addr | output | 16 | SRAM word address |
| sram_wdata | output | 16 | Packed 16-pixel word |

## Verification
Two collisions need attention. The first is a word that completes on the last pixel of a line. Its write strobe comes out in the same cycle that the following hsync clears the packing state. The bench provokes this by making the line length equal to the back porch plus a whole number of words, and it expects that final word at its computed address and data. The second is vsync and hsync rising on the same pixel. The bench starts fields that way and expects that same line to be captured as row 0, with the field parity taken from position 0. It then compares this with fields whose vsync lands mid-line and cuts the line short.

// File: rtl/vfw_pkg.sv
package vfw_pkg;

    parameter int VFW_POS_W   = 11;  // pixel position within a line
    parameter int VFW_WPL_W   = 8;   // words-per-line setting width
    parameter int VFW_ROW_W   = 10;  // row index within a field
    parameter int VFW_ADDR_W  = 16;  // SRAM word address width
    parameter int VFW_WORD_W  = 16;  // pixels per SRAM word (1 bit each)
    parameter int VFW_CSR_AW  = 4;
    parameter int VFW_CSR_DW  = 16;

    localparam int VFW_SLOT_W = VFW_ROW_W + 1;
    localparam int VFW_PROD_W = VFW_SLOT_W + VFW_WPL_W;
    localparam int VFW_CNT_W  = $clog2(VFW_WORD_W);

    typedef enum logic [VFW_CSR_AW-1:0] {
        CSR_CTRL  = VFW_CSR_AW'(0),
        CSR_PORCH = VFW_CSR_AW'(1),
        CSR_WPL   = VFW_CSR_AW'(2),
        CSR_BASE  = VFW_CSR_AW'(3)
    } csr_reg_e;

    typedef struct packed {
        logic                  enable;
        logic [VFW_POS_W-1:0]  back_porch;
        logic [VFW_WPL_W-1:0]  words_per_line;
        logic [VFW_ADDR_W-1:0] base;
    } vfw_cfg_t;

    typedef struct packed {
        logic                 line_start;
        logic                 field_start;
        logic [VFW_POS_W-1:0] pix_pos;
        logic [VFW_ROW_W-1:0] row;
        logic                 ilace;
        logic                 parity;
    } vfw_sync_t;

    // Framebuffer row slot: interleaved when interlaced.
    function automatic logic [VFW_SLOT_W-1:0] row_slot(
        input logic [VFW_ROW_W-1:0] row,
        input logic                 ilace,
        input logic                 parity
    );
        return ilace ? {row, parity} : {1'b0, row};
    endfunction

endpackage

// File: rtl/vfw_csr_regs.sv
module vfw_csr_regs
    import vfw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [VFW_CSR_AW-1:0] req_addr,
    input  logic [VFW_CSR_DW-1:0] req_wdata,
    output logic                  resp_valid,
    output logic [VFW_CSR_DW-1:0] resp_rdata,
    output vfw_cfg_t              cfg
);

    vfw_cfg_t              cfg_q;
    logic [VFW_CSR_DW-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        case (csr_reg_e'(req_addr))
            CSR_CTRL:  rd_val = VFW_CSR_DW'(cfg_q.enable);
            CSR_PORCH: rd_val = VFW_CSR_DW'(cfg_q.back_porch);
            CSR_WPL:   rd_val = VFW_CSR_DW'(cfg_q.words_per_line);
            CSR_BASE:  rd_val = VFW_CSR_DW'(cfg_q.base);
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= req_valid;
            resp_rdata <= (req_valid && !req_write) ? rd_val : '0;
            if (req_valid && req_write) begin
                case (csr_reg_e'(req_addr))
                    CSR_CTRL:  cfg_q.enable         <= req_wdata[0];
                    CSR_PORCH: cfg_q.back_porch     <= req_wdata[VFW_POS_W-1:0];
                    CSR_WPL:   cfg_q.words_per_line <= req_wdata[VFW_WPL_W-1:0];
                    CSR_BASE:  cfg_q.base           <= req_wdata[VFW_ADDR_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    assign cfg = cfg_q;

    AST_CSR_RESP_NEXT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid); // R10

    AST_CSR_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid); // R10

endmodule

// File: rtl/vfw_sync_tracker.sv
module vfw_sync_tracker
    import vfw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pix_valid,
    input  logic      hsync,
    input  logic      vsync,
    output vfw_sync_t info
);

    localparam logic [VFW_POS_W-1:0] POS_MAX = '1;

    logic                 hs_q, vs_q;
    logic [VFW_POS_W-1:0] pos_q;
    logic [VFW_ROW_W-1:0] row_q;
    logic                 pending_q;
    logic                 have_prev_q;
    logic [VFW_POS_W-1:0] prev_vs_q;
    logic                 ilace_q, parity_q;

    logic                 hs_rise, vs_rise;
    logic [VFW_POS_W-1:0] pos_cur;
    logic [VFW_ROW_W-1:0] row_cur;
    logic                 il_new, par_new, il_cur, par_cur;

    always_comb begin
        hs_rise = pix_valid && hsync && !hs_q;
        vs_rise = pix_valid && vsync && !vs_q;
        pos_cur = hs_rise ? '0 : pos_q;
        if (hs_rise)
            row_cur = (vs_rise || pending_q) ? '0 : row_q + VFW_ROW_W'(1);
        else
            row_cur = row_q;
        il_new  = have_prev_q && (pos_cur != prev_vs_q);
        par_new = il_new && (pos_cur > prev_vs_q);
        il_cur  = vs_rise ? il_new  : ilace_q;
        par_cur = vs_rise ? par_new : parity_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q        <= 1'b0;
            vs_q        <= 1'b0;
            pos_q       <= '0;
            row_q       <= '0;
            pending_q   <= 1'b1;
            have_prev_q <= 1'b0;
            prev_vs_q   <= '0;
            ilace_q     <= 1'b0;
            parity_q    <= 1'b0;
        end else if (pix_valid) begin
            hs_q      <= hsync;
            vs_q      <= vsync;
            pos_q     <= (pos_cur == POS_MAX) ? POS_MAX : pos_cur + VFW_POS_W'(1);
            row_q     <= row_cur;
            pending_q <= hs_rise ? 1'b0 : (vs_rise ? 1'b1 : pending_q);
            if (vs_rise) begin
                have_prev_q <= 1'b1;
                prev_vs_q   <= pos_cur;
                ilace_q     <= il_new;
                parity_q    <= par_new;
            end
        end
    end

    always_comb begin
        info.line_start  = hs_rise;
        info.field_start = vs_rise;
        info.pix_pos     = pos_cur;
        info.row         = row_cur;
        info.ilace       = il_cur;
        info.parity      = par_cur;
    end

    AST_POS_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> $stable(pos_q) && $stable(row_q)); // R2

    AST_FIELD_MODE_ON_VSYNC: assert property (@(posedge clk) disable iff (rst)
        !$stable(parity_q) |-> $past(vsync) && $past(pix_valid)); // R7

endmodule

// File: rtl/vfw_pixel_packer.sv
module vfw_pixel_packer
    import vfw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pix_valid,
    input  logic                  pix_data,
    input  vfw_sync_t             info,
    input  vfw_cfg_t              cfg,
    output logic                  wr_en,
    output logic [VFW_ADDR_W-1:0] wr_addr,
    output logic [VFW_WORD_W-1:0] wr_data
);

    logic                  live_q;
    logic [VFW_WORD_W-1:0] bits_q;
    logic [VFW_CNT_W-1:0]  cnt_q;
    logic [VFW_WPL_W-1:0]  word_q;
    logic                  we_q;
    logic [VFW_ADDR_W-1:0] addr_q;
    logic [VFW_WORD_W-1:0] data_q;

    logic                  restart, live_cur, take, complete;
    logic [VFW_CNT_W-1:0]  cnt_base;
    logic [VFW_WPL_W-1:0]  word_base;
    logic [VFW_WORD_W-1:0] shift_nxt;
    logic [VFW_SLOT_W-1:0] slot;
    logic [VFW_PROD_W-1:0] slot_prod;
    logic [VFW_ADDR_W-1:0] addr_calc;

    always_comb begin
        restart   = info.line_start || info.field_start;
        live_cur  = info.line_start ? 1'b1 : (info.field_start ? 1'b0 : live_q);
        cnt_base  = restart ? '0 : cnt_q;
        word_base = restart ? '0 : word_q;
        take      = pix_valid && live_cur
                    && (info.pix_pos >= cfg.back_porch)
                    && (word_base < cfg.words_per_line);
        complete  = take && (cnt_base == VFW_CNT_W'(VFW_WORD_W - 1));
        shift_nxt = {bits_q[VFW_WORD_W-2:0], pix_data};
        slot      = row_slot(info.row, info.ilace, info.parity);
        slot_prod = {{VFW_WPL_W{1'b0}}, slot} * {{VFW_SLOT_W{1'b0}}, cfg.words_per_line};
        addr_calc = cfg.base + slot_prod[VFW_ADDR_W-1:0]
                    + {{(VFW_ADDR_W-VFW_WPL_W){1'b0}}, word_base};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            bits_q <= '0;
            cnt_q  <= '0;
            word_q <= '0;
            we_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            we_q <= complete && cfg.enable;
            if (complete) begin
                addr_q <= addr_calc;
                data_q <= shift_nxt;
            end
            if (pix_valid) begin
                live_q <= live_cur;
                if (take) begin
                    bits_q <= shift_nxt;
                    cnt_q  <= complete ? '0 : cnt_base + VFW_CNT_W'(1);
                    word_q <= complete ? word_base + VFW_WPL_W'(1) : word_base;
                end else begin
                    cnt_q  <= cnt_base;
                    word_q <= word_base;
                end
            end
        end
    end

    assign wr_en   = we_q;
    assign wr_addr = addr_q;
    assign wr_data = data_q;

    AST_WR_AFTER_PIXEL: assert property (@(posedge clk) disable iff (rst)
        we_q |-> $past(pix_valid)); // R4

    AST_WR_PAST_PORCH: assert property (@(posedge clk) disable iff (rst)
        we_q |-> ($past(info.pix_pos) >= $past(cfg.back_porch))); // R3

endmodule

// File: rtl/vidcap_fb_writer.sv
module vidcap_fb_writer
    import vfw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pix_valid,
    input  logic                  pix_data,
    input  logic                  hsync,
    input  logic                  vsync,
    input  logic                  csr_req_valid,
    input  logic                  csr_req_write,
    input  logic [VFW_CSR_AW-1:0] csr_req_addr,
    input  logic [VFW_CSR_DW-1:0] csr_req_wdata,
    output logic                  csr_resp_valid,
    output logic [VFW_CSR_DW-1:0] csr_resp_rdata,
    output logic                  sram_we,
    output logic [VFW_ADDR_W-1:0] sram_addr,
    output logic [VFW_WORD_W-1:0] sram_wdata
);

    vfw_cfg_t  cfg;
    vfw_sync_t info;

    vfw_csr_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (csr_req_valid),
        .req_write  (csr_req_write),
        .req_addr   (csr_req_addr),
        .req_wdata  (csr_req_wdata),
        .resp_valid (csr_resp_valid),
        .resp_rdata (csr_resp_rdata),
        .cfg        (cfg)
    );

    vfw_sync_tracker u_sync (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .hsync     (hsync),
        .vsync     (vsync),
        .info      (info)
    );

    vfw_pixel_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .info      (info),
        .cfg       (cfg),
        .wr_en     (sram_we),
        .wr_addr   (sram_addr),
        .wr_data   (sram_wdata)
    );

    AST_WR_GATED: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> $past(cfg.enable)); // R9

    AST_WR_SINGLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sram_we); // R1

endmodule

// File: tb/vidcap_fb_writer_bench.sv
module vidcap_fb_writer_bench;
    import vfw_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        pix_valid, pix_data, hsync, vsync;
    logic        csr_req_valid, csr_req_write;
    logic [3:0]  csr_req_addr;
    logic [15:0] csr_req_wdata;
    logic        csr_resp_valid;
    logic [15:0] csr_resp_rdata;
    logic        sram_we;
    logic [15:0] sram_addr, sram_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    vidcap_fb_writer u_vidcap_fb_writer (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
        .hsync(hsync), .vsync(vsync),
        .csr_req_valid(csr_req_valid), .csr_req_write(csr_req_write),
        .csr_req_addr(csr_req_addr), .csr_req_wdata(csr_req_wdata),
        .csr_resp_valid(csr_resp_valid), .csr_resp_rdata(csr_resp_rdata),
        .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] q_addr[$];
    logic [15:0] q_data[$];
    string       q_tag[$];

    // bench model of the settings and of field/row tracking
    int c_bp, c_wpl, c_base;
    bit c_en;
    int m_row = 0;
    bit m_pend = 1;
    bit m_have = 0;
    int m_prev = 0;
    bit m_il = 0, m_par = 0;
    int seed = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit pixel_of(input int s, input int p);
        return (((p * 37 + s * 11 + (p >> 3)) >> 2) % 2) == 1;
    endfunction

    // write monitor
    logic [15:0] mon_a, mon_d;
    string       mon_t;
    always @(negedge clk) begin
        if (!rst && sram_we) begin
            if (q_addr.size() == 0) begin
                check(1'b0, "R9", "unexpected write at addr", int'(sram_addr), 0);
            end else begin
                mon_a = q_addr.pop_front();
                mon_d = q_data.pop_front();
                mon_t = q_tag.pop_front();
                check(sram_addr == mon_a, mon_t, "write addr", int'(sram_addr), int'(mon_a));
                check(sram_wdata == mon_d, mon_t, "write data", int'(sram_wdata), int'(mon_d));
            end
        end
    end

    task automatic csr_wr(input int a, input int d);
        @(negedge clk);
        csr_req_valid = 1; csr_req_write = 1;
        csr_req_addr = 4'(a); csr_req_wdata = 16'(d);
        @(negedge clk);
        csr_req_valid = 0; csr_req_write = 0;
    endtask

    task automatic csr_rd(input int a, output int d, output bit v);
        @(negedge clk);
        csr_req_valid = 1; csr_req_write = 0; csr_req_addr = 4'(a);
        @(negedge clk);
        csr_req_valid = 0;
        d = int'(csr_resp_rdata);
        v = csr_resp_valid;
    endtask

    task automatic setup(input int bp, input int wpl, input int base, input bit en);
        csr_wr(1, bp); csr_wr(2, wpl); csr_wr(3, base); csr_wr(0, int'(en));
        c_bp = bp; c_wpl = wpl; c_base = base; c_en = en;
    endtask

    function automatic void field_update(input int p);
        bit nil;
        nil    = m_have && (p != m_prev);
        m_par  = nil && (p > m_prev);
        m_il   = nil;
        m_prev = p;
        m_have = 1;
    endfunction

    // one display line; vs_at < 0: no vsync, else vsync rises at that position
    task automatic send_line(input int len, input int vs_at, input int gap, input string tag);
        int row, lim, slot, last;
        logic [15:0] d;
        seed++;
        if (vs_at == 0) begin
            field_update(0);
            row = 0;
        end else begin
            row = m_pend ? 0 : m_row + 1;
        end
        m_pend = 0;
        m_row  = row;
        lim  = (vs_at > 0) ? vs_at : len;
        slot = m_il ? row * 2 + int'(m_par) : row;
        if (c_en) begin
            for (int k = 0; k < c_wpl; k++) begin
                last = c_bp + 16 * k + 15;
                if (last < lim) begin
                    for (int i = 0; i < 16; i++)
                        d[15 - i] = pixel_of(seed, c_bp + 16 * k + i);
                    q_addr.push_back(16'((c_base + slot * c_wpl + k) & 16'hFFFF));
                    q_data.push_back(d);
                    q_tag.push_back(tag);
                end
            end
        end
        if (vs_at > 0) begin
            field_update(vs_at);
            m_pend = 1;
        end
        for (int p = 0; p < len; p++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                pix_valid = 0; hsync = 1; vsync = 1;
                pix_data = ~pixel_of(seed, p);
            end
            @(negedge clk);
            pix_valid = 1;
            hsync = (p < 2);
            vsync = (vs_at >= 0) && (p >= vs_at);
            pix_data = pixel_of(seed, p);
        end
        @(negedge clk);
        pix_valid = 0; hsync = 0; vsync = 0;
    endtask

    task automatic drain(input string tag);
        repeat (4) @(negedge clk);
        check(q_addr.size() == 0, tag, "expected writes still outstanding", q_addr.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int rd;
        bit rv;
        rst = 1;
        pix_valid = 0; pix_data = 0; hsync = 0; vsync = 0;
        csr_req_valid = 0; csr_req_write = 0; csr_req_addr = 0; csr_req_wdata = 0;
        repeat (4) @(negedge clk);
        rst = 0;

        // R1: reset state
        check(sram_we == 1'b0, "R1", "sram_we after reset", int'(sram_we), 0);
        for (int a = 0; a < 4; a++) begin
            csr_rd(a, rd, rv);
            check(rd == 0, "R1", "register reset value", rd, 0);
        end

        // R10: register map, masking, response timing
        csr_wr(1, 16'hFFFF);
        csr_rd(1, rd, rv);
        check(rd == 16'h07FF, "R10", "porch readback masked", rd, 16'h07FF);
        check(rv == 1'b1, "R10", "read response valid", int'(rv), 1);
        csr_wr(2, 16'h01FF);
        csr_rd(2, rd, rv);
        check(rd == 16'h00FF, "R10", "words per line readback", rd, 16'h00FF);
        csr_wr(3, 16'hA5C3);
        csr_rd(3, rd, rv);
        check(rd == 16'hA5C3, "R10", "base readback", rd, 16'hA5C3);
        csr_wr(0, 16'hFFFE);
        csr_rd(0, rd, rv);
        check(rd == 0, "R10", "enable takes bit 0 only", rd, 0);
        csr_wr(9, 16'h1234);
        csr_rd(9, rd, rv);
        check(rd == 0, "R10", "unmapped address reads 0", rd, 0);
        csr_rd(3, rd, rv);
        check(rd == 16'hA5C3, "R10", "unmapped write leaves base", rd, 16'hA5C3);

        // R4/R6: main capture, field start coincident with line start
        setup(10, 4, 16'h0100, 1);
        send_line(100, 0, 0, "R6");
        send_line(100, -1, 0, "R4");
        send_line(100, -1, 0, "R4");
        // R2: idle cycles carrying junk between pixels
        send_line(100, -1, 1, "R2");
        send_line(100, -1, 3, "R2");
        drain("R4");

        // R3: back-porch sweep
        for (int bp = 0; bp < 50; bp += 7) begin
            setup(bp, 3, 16'h0040, 1);
            send_line(80, -1, 0, "R3");
        end
        drain("R3");

        // R5: partial word dropped; word completed on last pixel kept
        setup(10, 8, 16'h0000, 1);
        send_line(100, -1, 0, "R5");
        setup(4, 4, 16'h0000, 1);
        send_line(68, -1, 0, "R5");
        send_line(68, -1, 0, "R5");
        drain("R5");

        // R6/R7: vsync mid-line, interlaced fields
        setup(10, 4, 16'h0200, 1);
        send_line(100, 40, 0, "R6");
        send_line(100, -1, 0, "R7");
        send_line(100, -1, 0, "R7");
        send_line(100, 0, 0, "R7");
        send_line(100, -1, 0, "R7");
        send_line(100, -1, 0, "R7");
        send_line(100, 0, 0, "R7");
        send_line(100, -1, 0, "R7");
        drain("R7");

        // R8: address arithmetic with several widths and wrap
        setup(0, 1, 16'h0010, 1);
        send_line(40, -1, 0, "R8");
        setup(2, 5, 16'hFFF0, 1);
        send_line(90, -1, 0, "R8");
        send_line(90, -1, 0, "R8");
        setup(0, 2, 16'h0300, 1);
        send_line(40, -1, 0, "R8");
        drain("R8");

        // R9: disabled writes while tracking continues
        setup(10, 4, 16'h0100, 0);
        send_line(100, -1, 0, "R9");
        send_line(100, -1, 0, "R9");
        send_line(100, 30, 0, "R9");
        send_line(100, -1, 0, "R9");
        drain("R9");
        setup(10, 4, 16'h0100, 1);
        send_line(100, -1, 0, "R9");
        send_line(100, -1, 0, "R9");
        drain("R9");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule